// File: doc/BRIEF.md
# Trigger-Gated Burst Capture

This block sits between a free-running sample source and a streaming consumer such as a RAM writer. It watches an asynchronous trigger line. Each rising edge of that line opens a capture window in which exactly N valid samples pass downstream, after which the window closes until the next edge. Outside a window the stream output stays idle and produces no filler values. A downstream buffer therefore advances its write address only for wanted data. Consecutive bursts join into one unbroken stream that a host can read as a plain pipe of N times the number of bursts.

N comes from a 16-bit runtime input. It is latched when a window opens, and a value of zero turns capture off. Trigger edges that arrive while a window is still open are counted as dropped. A sample that arrives while the output register still holds an unaccepted beat is discarded, and a sticky overflow flag is set. A 32-bit count of completed bursts is provided for status. The window length has to fit the sample rate: N samples must finish within the active phase of the trigger, which is about 300 µs out of a period of roughly 950 µs.

Top module: `trig_burst_gate`

## Requirements
- R1: During synchronous reset (rst high) and right after it, mTvalid, mTlast, burstCount, dropCount and overflowFlag are all 0.
- R2: A window opens only on a low-to-high transition of trigIn, after a two-flop synchroniser. A trigger that stays high after a window has finished does not open another window.
- R3: Inside a window, the first N samples that have sampleValid high come out on mTdata in their original order. Outside a window, mTvalid stays low regardless of the sample input.
- R4: mTlast is 1 on the N-th beat of a window and 0 on every other beat.
- R5: A cycle with sampleValid low forwards nothing and does not advance the count within the window.
- R6: burstLen is latched when a window opens. Changing it during a window does not change that window's length.
- R7: When burstLen is 0, a trigger edge opens no window, produces no output and leaves burstCount and dropCount unchanged.
- R8: A rising trigger edge that arrives while a window is open is ignored and adds 1 to dropCount.
- R9: burstCount goes up by exactly 1 for each completed window. It changes on the cycle in which that window's final beat appears on the output.
- R10: A sample that arrives inside a window while mTvalid is 1 and mTready is 0 is discarded and not counted, and overflowFlag becomes 1 and stays 1 until reset.
- R11: While mTvalid is 1 and mTready is 0, mTvalid, mTdata and mTlast hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trigIn | input | 1 | Asynchronous trigger line |
| sampleData | input | DATA_W | Sample value |
| sampleValid | input | 1 | Sample qualifier |
| burstLen | input | LEN_W | Window length in samples; 0 disables capture |
| mTdata | output | DATA_W | Stream data |
| mTvalid | output | 1 | Stream valid |
| mTready | input | 1 | Stream ready from the consumer |
| mTlast | output | 1 | Final beat of a window |
| burstCount | output | BCNT_W | Completed windows |
| dropCount | output | DCNT_W | Trigger edges ignored during an open window |
| overflowFlag | output | 1 | Sticky flag: a sample was lost to backpressure |

## Verification
The properties assume that the consumer obeys the stream handshake and that the counters do not wrap within a run. The stimulus meets both assumptions: bursts are short, the count of bursts is small, and mTready drops only for a few cycles at a time. The properties also assume that trigIn holds each level long enough to pass through the synchroniser. The bench therefore holds every trigger level for at least four cycles, and it raises sampleValid only once a window has had time to open. This keeps the expected data exact.

// File: rtl/tbg_pkg.sv
package tbg_pkg;
  typedef struct packed {
    logic load;       // accept current sample into output register
    logic last;       // accepted sample closes the window
    logic burstDone;  // window completed
    logic dropEdge;   // trigger edge ignored while open
    logic overflow;   // sample lost to backpressure
  } tbgStrobe_t;
endpackage

// File: rtl/tbg_ctrl.sv
module tbg_ctrl
  import tbg_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trigIn,
  input  logic             sampleValid,
  input  logic [LEN_W-1:0] burstLen,
  input  logic             outBusy,
  output tbgStrobe_t       strb
);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  logic [SYNC_N-1:0] trigSync;
  logic              trigPrev;
  logic              trigEdge;
  logic              windowOpen;
  logic [LEN_W-1:0]  lenHeld;
  logic [LEN_W-1:0]  sampleIdx;
  logic              wanted;

  assign trigEdge = trigSync[SYNC_N-1] & ~trigPrev;
  assign wanted   = windowOpen & sampleValid;

  always_comb begin
    strb           = '0;
    strb.load      = wanted & ~outBusy;
    strb.overflow  = wanted & outBusy;
    strb.last      = strb.load & (sampleIdx == lenHeld - LEN_ONE);
    strb.burstDone = strb.last;
    strb.dropEdge  = trigEdge & windowOpen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trigSync   <= '0;
      trigPrev   <= 1'b0;
      windowOpen <= 1'b0;
      lenHeld    <= '0;
      sampleIdx  <= '0;
    end else begin
      trigSync <= {trigSync[SYNC_N-2:0], trigIn};
      trigPrev <= trigSync[SYNC_N-1];
      if (!windowOpen) begin
        if (trigEdge && burstLen != '0) begin
          windowOpen <= 1'b1;
          lenHeld    <= burstLen;
          sampleIdx  <= '0;
        end
      end else if (strb.load) begin
        if (strb.last) windowOpen <= 1'b0;
        else           sampleIdx  <= sampleIdx + LEN_ONE;
      end
    end
  end
endmodule

// File: rtl/tbg_datapath.sv
module tbg_datapath
  import tbg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BCNT_W = 32,
  parameter int DCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  tbgStrobe_t        strb,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              mTready,
  output logic [DATA_W-1:0] mTdata,
  output logic              mTvalid,
  output logic              mTlast,
  output logic              outBusy,
  output logic [BCNT_W-1:0] burstCount,
  output logic [DCNT_W-1:0] dropCount,
  output logic              overflowFlag
);
  assign outBusy = mTvalid & ~mTready;

  always_ff @(posedge clk) begin
    if (rst) begin
      mTdata  <= '0;
      mTvalid <= 1'b0;
      mTlast  <= 1'b0;
    end else if (strb.load) begin
      mTdata  <= sampleData;
      mTvalid <= 1'b1;
      mTlast  <= strb.last;
    end else if (mTready) begin
      mTvalid <= 1'b0;
      mTlast  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burstCount   <= '0;
      dropCount    <= '0;
      overflowFlag <= 1'b0;
    end else begin
      if (strb.burstDone) burstCount <= burstCount + BCNT_W'(1);
      if (strb.dropEdge)  dropCount  <= dropCount + DCNT_W'(1);
      if (strb.overflow)  overflowFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/trig_burst_gate.sv
module trig_burst_gate
  import tbg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 16,
  parameter int BCNT_W = 32,
  parameter int DCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trigIn,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              sampleValid,
  input  logic [LEN_W-1:0]  burstLen,
  output logic [DATA_W-1:0] mTdata,
  output logic              mTvalid,
  input  logic              mTready,
  output logic              mTlast,
  output logic [BCNT_W-1:0] burstCount,
  output logic [DCNT_W-1:0] dropCount,
  output logic              overflowFlag
);
  tbgStrobe_t strb;
  logic       outBusy;

  tbg_ctrl #(.LEN_W(LEN_W), .SYNC_N(2)) i_ctrl (
    .clk(clk), .rst(rst), .trigIn(trigIn), .sampleValid(sampleValid),
    .burstLen(burstLen), .outBusy(outBusy), .strb(strb)
  );

  tbg_datapath #(.DATA_W(DATA_W), .BCNT_W(BCNT_W), .DCNT_W(DCNT_W)) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .sampleData(sampleData),
    .mTready(mTready), .mTdata(mTdata), .mTvalid(mTvalid), .mTlast(mTlast),
    .outBusy(outBusy), .burstCount(burstCount), .dropCount(dropCount),
    .overflowFlag(overflowFlag)
  );
endmodule

// File: rtl/tbg_checker.sv
module tbg_checker #(
  parameter int DATA_W = 16,
  parameter int BCNT_W = 32,
  parameter int DCNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] mTdata,
  input logic              mTvalid,
  input logic              mTready,
  input logic              mTlast,
  input logic [BCNT_W-1:0] burstCount,
  input logic [DCNT_W-1:0] dropCount,
  input logic              overflowFlag
);
  // R11
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (mTvalid && !mTready) |=> (mTvalid && $stable(mTdata) && $stable(mTlast)));

  // R4
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    mTlast |-> mTvalid);

  // R9
  burst_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (burstCount == $past(burstCount) ||
              burstCount == $past(burstCount) + BCNT_W'(1)));

  // R9
  burst_on_last_chk: assert property (@(posedge clk) disable iff (rst)
    (burstCount != $past(burstCount)) |-> (mTvalid && mTlast));

  // R8
  drop_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dropCount == $past(dropCount) ||
              dropCount == $past(dropCount) + DCNT_W'(1)));

  // R10
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflowFlag |=> overflowFlag);
endmodule

bind trig_burst_gate tbg_checker #(.DATA_W(DATA_W), .BCNT_W(BCNT_W), .DCNT_W(DCNT_W)) i_chk (
  .clk(clk), .rst(rst), .mTdata(mTdata), .mTvalid(mTvalid), .mTready(mTready),
  .mTlast(mTlast), .burstCount(burstCount), .dropCount(dropCount),
  .overflowFlag(overflowFlag)
);

// File: tb/test_trig_burst_gate.sv
module test_trig_burst_gate;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              trigIn = 1'b0;
  logic [DATA_W-1:0] sampleData = '0;
  logic              sampleValid = 1'b0;
  logic [15:0]       burstLen = 16'd0;
  logic [DATA_W-1:0] mTdata;
  logic              mTvalid;
  logic              mTready = 1'b1;
  logic              mTlast;
  logic [31:0]       burstCount;
  logic [15:0]       dropCount;
  logic              overflowFlag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [DATA_W:0] expQ[$];

  always #5 clk = ~clk;

  trig_burst_gate i_trig_burst_gate (
    .clk(clk), .rst(rst), .trigIn(trigIn), .sampleData(sampleData),
    .sampleValid(sampleValid), .burstLen(burstLen), .mTdata(mTdata),
    .mTvalid(mTvalid), .mTready(mTready), .mTlast(mTlast),
    .burstCount(burstCount), .dropCount(dropCount), .overflowFlag(overflowFlag)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // driver: one sample for one cycle, optionally expected downstream
  task automatic sendSample(input logic [DATA_W-1:0] d, input bit expect_out, input bit isLast);
    sampleData  = d;
    sampleValid = 1'b1;
    if (expect_out) expQ.push_back({isLast, d});
    tick(1);
    sampleValid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && mTvalid && mTready) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3 unexpected beat", mTdata, -1);
      end else begin
        logic [DATA_W:0] e;
        e = expQ.pop_front();
        check(mTdata == e[DATA_W-1:0], "R3 data order", mTdata, e[DATA_W-1:0]);
        check(mTlast == e[DATA_W], "R4 last flag", mTlast, e[DATA_W]);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    finishRun();
  end

  initial begin
    tick(4);
    // R1 reset state
    check(mTvalid == 0, "R1 valid", mTvalid, 0);
    check(burstCount == 0 && dropCount == 0, "R1 counters", burstCount + dropCount, 0);
    check(overflowFlag == 0, "R1 overflow", overflowFlag, 0);
    rst = 1'b0;
    tick(2);
    check(mTvalid == 0 && mTlast == 0, "R1 after release", mTvalid, 0);

    // R3 idle: samples without trigger ignored
    for (int i = 0; i < 3; i++) sendSample(16'h0F00 + 16'(i), 1'b0, 1'b0);
    tick(3);
    check(mTvalid == 0, "R3 idle no output", mTvalid, 0);

    // burst A: length 5, change length mid-window (R6), gaps (R5)
    burstLen = 16'd5;
    trigIn = 1'b1;
    tick(6);
    burstLen = 16'd9;
    for (int i = 0; i < 5; i++) begin
      sendSample(16'h0A00 + 16'(i), 1'b1, i == 4);
      tick(i % 2);  // R5 idle cycles in between
    end
    for (int i = 0; i < 3; i++) sendSample(16'h0AF0 + 16'(i), 1'b0, 1'b0);
    tick(3);
    check(burstCount == 1, "R9 one burst", burstCount, 1);
    check(expQ.size() == 0, "R6 old length used", expQ.size(), 0);
    // R2 trigger still high: no new window
    for (int i = 0; i < 2; i++) sendSample(16'h0AA0 + 16'(i), 1'b0, 1'b0);
    tick(3);
    check(burstCount == 1, "R2 level no retrigger", burstCount, 1);

    // burst B: length 9 latched, second edge during window (R8)
    trigIn = 1'b0;
    tick(5);
    trigIn = 1'b1;
    tick(6);
    trigIn = 1'b0;
    tick(5);
    trigIn = 1'b1;
    tick(6);
    check(dropCount == 1, "R8 drop counted", dropCount, 1);
    for (int i = 0; i < 9; i++) sendSample(16'h0B00 + 16'(i), 1'b1, i == 8);
    sendSample(16'h0BFF, 1'b0, 1'b0);
    tick(3);
    check(burstCount == 2, "R9 two bursts", burstCount, 2);

    // R7 length zero disables
    trigIn = 1'b0;
    burstLen = 16'd0;
    tick(5);
    trigIn = 1'b1;
    tick(6);
    for (int i = 0; i < 3; i++) sendSample(16'h0C00 + 16'(i), 1'b0, 1'b0);
    tick(3);
    check(burstCount == 2, "R7 no burst", burstCount, 2);
    check(dropCount == 1, "R7 no drop", dropCount, 1);
    check(mTvalid == 0, "R7 no output", mTvalid, 0);

    // R10/R11 overflow under backpressure, length 3
    trigIn = 1'b0;
    burstLen = 16'd3;
    tick(5);
    trigIn = 1'b1;
    tick(6);
    mTready = 1'b0;
    sendSample(16'h0D01, 1'b1, 1'b0);
    sendSample(16'h0D02, 1'b0, 1'b0);
    tick(2);
    check(overflowFlag == 1, "R10 overflow set", overflowFlag, 1);
    check(mTvalid == 1 && mTdata == 16'h0D01, "R11 held beat", mTdata, 16'h0D01);
    mTready = 1'b1;
    tick(1);
    sendSample(16'h0D03, 1'b1, 1'b0);
    sendSample(16'h0D04, 1'b1, 1'b1);
    tick(3);
    check(burstCount == 3, "R10 dropped sample not counted", burstCount, 3);
    check(overflowFlag == 1, "R10 sticky", overflowFlag, 1);
    check(expQ.size() == 0, "R3 all beats seen", expQ.size(), 0);
    finishRun();
  end
endmodule